// File: doc/BRIEF.md
# Background Mismatch-Noise Cancellation Engine

This block sits at the digital back end of a pipelined converter whose first stage selects its capacitors under the control of three pseudo-random ±1 sequences. Because of that selection, any capacitor mismatch in the first stage shows up in the word delivered by the later stages as a term that is correlated with those sequences. The engine produces the sequences and correlates the back-end word against each one. From that correlation it learns one signed mismatch coefficient per sequence. It then removes the sum of sequence-times-coefficient from every sample and merges the cleaned residue with the 3-bit first-stage code into a 14-bit result.

All of this runs on live conversion data. Every sample marked valid advances the sequences, feeds the accumulators and produces an output two cycles later. Coefficients are refreshed once per block of 2^K valid samples. After a reset all coefficients are zero, so the output path passes samples through without correction until the first block completes.

Top module: `mnc_engine`

## Requirements
- R1: A synchronous reset makes every coefficient zero, clears `out_valid` and loads each sequence generator with its seed. With the default seeds, this gives `pn_out` = 3'b110.
- R2: Each sequence comes from a 15-bit shift register. On each valid sample it shifts left and takes in `s[14]^s[13]` at bit 0. `pn_out[i]` is `s[0]`, where 1 means +1 and 0 means −1. An all-zero state is never kept: it reloads the seed.
- R3: While `in_valid` is low, `pn_out` does not change.
- R4: `out_valid` equals `in_valid` delayed by exactly two clock cycles.
- R5: At the end of a block, coefficient i becomes the block's sum of (pn_i ? be : −be) arithmetically shifted right by K−4. This gives a two's-complement value with 4 fractional bits, held in bits [i·CW +: CW] of `coef_all`, where CW = BW+5.
- R6: Coefficients change only in the cycle after the 2^K-th valid sample since reset or since the previous update.
- R7: For a sample with code c and word be, `out_word` = clamp(c·2^(OW−3) + floor((16·be − Σ s_i·coef_i + 8)/16)). Here s_i is ±1 from the sample's own `pn_out` bits, and coef_i is the value present one cycle after the sample was taken.
- R8: The result saturates to the range 0 to 2^14−1.
- R9: Before the first block completes, `out_word` equals c·2^(OW−3) + be exactly.
- R10: When the back-end word carries injected terms ±Δ_i that follow the sequences, each learned coefficient lies within 1 LSB (16 fractional units) of 16·Δ_i after one block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the current sample |
| stage_code | input | SB (3) | First-stage code of the sample |
| be_word | input | BW (12) | Signed back-end residue word |
| pn_out | output | NCH (3) | Sequence bits applied to the current sample (1 = +1) |
| out_valid | output | 1 | Output sample strobe |
| out_word | output | OW (14) | Corrected, combined output |
| coef_all | output | NCH·CW (51) | Learned coefficients, packed per channel |

## Verification
The estimator is first driven with a sign-following injection of three distinct mismatch values on top of a small triangle. This checks that each coefficient separates out its own sequence and is not disturbed by the others. Single spaced samples before the first estimate, with mixed codes and words, show that the path is transparent. The same kind of samples after the estimate show that the correction is subtracted with the correct sign and rounding. Extreme words paired with a chosen sequence state push the cleaned value past both ends of the range, which exercises the clamp. A reset in mid-run confirms that learned state is discarded.

// File: rtl/mnc_engine.sv
`timescale 1ns/1ps
module mnc_engine #(
  parameter int BW  = 12,
  parameter int OW  = 14,
  parameter int SB  = 3,
  parameter int NCH = 3,
  parameter int K   = 16,
  parameter int FB  = 4,
  parameter int LW  = 15,
  parameter logic [NCH*LW-1:0] SEEDS = {15'h4C53, 15'h2B35, 15'h1ACE},
  localparam int CW = BW + FB + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [SB-1:0]         stage_code,
  input  logic signed [BW-1:0]  be_word,
  output logic [NCH-1:0]        pn_out,
  output logic                  out_valid,
  output logic [OW-1:0]         out_word,
  output logic [NCH*CW-1:0]     coef_all
);
  localparam int AW   = BW + K + 1;
  localparam int SW   = CW + $clog2(NCH) + 1;
  localparam int DW   = SW + 1;
  localparam int XW   = ((OW > DW - FB) ? OW : DW - FB) + 2;
  localparam int HALF = 1 << (FB - 1);
  localparam logic signed [XW-1:0] TOPV = XW'((1 << OW) - 1);

  logic [K-1:0]          cnt;
  logic                  blk_end;
  logic [NCH*LW-1:0]     lfsr_all;
  logic                  v1;
  logic [SB-1:0]         code1;
  logic signed [BW-1:0]  be1;
  logic [NCH-1:0]        pn1;
  logic signed [SW-1:0]  cterm [NCH];
  logic signed [SW-1:0]  csum;
  logic [OW-1:0]         sat_word;

  assign blk_end = in_valid && (&cnt);

  always_ff @(posedge clk)
    if (rst) cnt <= '0;
    else if (in_valid) cnt <= cnt + 1'b1;

  for (genvar g = 0; g < NCH; g++) begin : ch
    logic [LW-1:0]         st;
    logic signed [AW-1:0]  acc;
    logic signed [CW-1:0]  coef;
    logic signed [AW-1:0]  term;
    logic signed [AW-1:0]  acc_nx;

    assign term   = pn_out[g] ? AW'(be_word) : -AW'(be_word);
    assign acc_nx = acc + term;

    always_ff @(posedge clk)
      if (rst || st == '0) st <= SEEDS[g*LW +: LW];
      else if (in_valid)   st <= {st[LW-2:0], st[LW-1] ^ st[LW-2]};

    always_ff @(posedge clk)
      if (rst) begin
        acc  <= '0;
        coef <= '0;
      end else if (in_valid) begin
        if (blk_end) begin
          coef <= CW'(acc_nx >>> (K - FB));
          acc  <= '0;
        end else begin
          acc  <= acc_nx;
        end
      end

    assign pn_out[g]                = st[0];
    assign lfsr_all[g*LW +: LW]     = st;
    assign coef_all[g*CW +: CW]     = coef;
    assign cterm[g] = pn1[g] ? SW'(coef) : -SW'(coef);
  end

  always_ff @(posedge clk)
    if (rst) begin
      v1 <= 1'b0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        code1 <= stage_code;
        be1   <= be_word;
        pn1   <= pn_out;
      end
    end

  always_comb begin
    csum = '0;
    for (int i = 0; i < NCH; i++) csum = csum + cterm[i];
  end

  logic signed [DW-1:0] diff, rsum, rnd;
  logic signed [XW-1:0] comb;
  assign diff = (DW'(be1) <<< FB) - DW'(csum);
  assign rsum = diff + DW'(HALF);
  assign rnd  = rsum >>> FB;
  assign comb = (XW'($signed({1'b0, code1})) <<< (OW - SB)) + XW'(rnd);

  always_comb
    if (comb < 0)         sat_word = '0;
    else if (comb > TOPV) sat_word = '1;
    else                  sat_word = comb[OW-1:0];

  always_ff @(posedge clk)
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_word <= sat_word;
    end
endmodule

module mnc_engine_chk #(
  parameter int NCH = 3,
  parameter int LW  = 15,
  parameter int CW  = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [NCH-1:0]    pn_out,
  input logic              out_valid,
  input logic [NCH*CW-1:0] coef_all,
  input logic              blk_end,
  input logic [NCH*LW-1:0] lfsr_all
);
  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (coef_all == '0 && !out_valid));

  for (genvar g = 0; g < NCH; g++) begin : nz
    assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
      lfsr_all[g*LW +: LW] != '0);
  end

  assert_pn_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pn_out));

  assert_valid_rise_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  assert_valid_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  assert_coef_block_R6: assert property (@(posedge clk) disable iff (rst)
    !blk_end |=> $stable(coef_all));
endmodule

bind mnc_engine mnc_engine_chk #(.NCH(NCH), .LW(LW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .pn_out(pn_out),
  .out_valid(out_valid), .coef_all(coef_all), .blk_end(blk_end),
  .lfsr_all(lfsr_all));

// File: tb/sim_mnc_engine.sv
`timescale 1ns/1ps
module sim_mnc_engine;
  localparam int KB = 14;
  localparam int NB = 1 << KB;
  localparam int CW = 17;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [2:0] stage_code = '0;
  logic signed [11:0] be_word = '0;
  logic [2:0] pn_out;
  logic out_valid;
  logic [13:0] out_word;
  logic [3*CW-1:0] coef_all;

  mnc_engine #(.K(KB)) u0 (.clk(clk), .rst(rst), .in_valid(in_valid),
    .stage_code(stage_code), .be_word(be_word), .pn_out(pn_out),
    .out_valid(out_valid), .out_word(out_word), .coef_all(coef_all));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int d [3] = '{12, -7, 5};
  logic [14:0] seeds [3] = '{15'h1ACE, 15'h2B35, 15'h4C53};
  logic [14:0] m [3];
  longint sum [3];
  longint exp_coef [3];
  int cnt;
  logic [2:0] last_pn;

  task automatic chk(input string r, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, expv);
    end
  endtask

  function automatic logic [2:0] mpn();
    return {m[2][0], m[1][0], m[0][0]};
  endfunction

  function automatic int inj();
    int s = 0;
    for (int i = 0; i < 3; i++) s += m[i][0] ? d[i] : -d[i];
    return s;
  endfunction

  function automatic longint coef_at(input int i);
    return longint'($signed(coef_all[i*CW +: CW]));
  endfunction

  function automatic longint calc(input int code, input int be, input logic [2:0] pn,
                                  input longint c [3]);
    longint cs = 0, r, v;
    for (int i = 0; i < 3; i++) cs += pn[i] ? c[i] : -c[i];
    r = (longint'(be) * 16 - cs + 8) >>> 4;
    v = longint'(code) * 2048 + r;
    if (v < 0) v = 0;
    if (v > 16383) v = 16383;
    return v;
  endfunction

  task automatic drive(input int code, input int be);
    chk("R2 pn", pn_out, mpn());
    last_pn = mpn();
    in_valid = 1; stage_code = 3'(code); be_word = 12'(be);
    for (int i = 0; i < 3; i++) begin
      sum[i] += last_pn[i] ? be : -be;
      m[i] = {m[i][13:0], m[i][14] ^ m[i][13]};
    end
    cnt++;
    if (cnt == NB) begin
      for (int i = 0; i < 3; i++) begin
        exp_coef[i] = sum[i] >>> (KB - 4);
        sum[i] = 0;
      end
      cnt = 0;
    end
    @(negedge clk);
  endtask

  task automatic gap();
    in_valid = 0;
    @(negedge clk);
  endtask

  task automatic one_shot(input int code, input int be, input string r, output longint got);
    longint c [3];
    longint e;
    drive(code, be);
    in_valid = 0;
    for (int i = 0; i < 3; i++) c[i] = coef_at(i);
    chk("R4 early", out_valid, 0);
    @(negedge clk);
    chk("R4 due", out_valid, 1);
    e = calc(code, be, last_pn, c);
    got = out_word;
    chk(r, got, e);
    @(negedge clk);
    chk("R4 after", out_valid, 0);
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 3; i++) begin
      m[i] = seeds[i]; sum[i] = 0; exp_coef[i] = 0;
    end
    cnt = 0;
    @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 coef", coef_all, 0);
    chk("R1 pn seed", pn_out, 3'b110);
  endtask

  task automatic t_pn_walk();
    logic [2:0] p;
    for (int i = 0; i < 40; i++) drive(3, inj());
    gap();
    p = pn_out;
    repeat (6) begin
      gap();
      chk("R3 pn hold", pn_out, p);
    end
  endtask

  task automatic t_transparent();
    longint g;
    one_shot(5, 100, "R7", g);   chk("R9 pass", g, 5 * 2048 + 100);
    one_shot(2, -37, "R7", g);   chk("R9 pass", g, 2 * 2048 - 37);
    one_shot(7, 2047, "R7", g);  chk("R9 top", g, 16383);
    one_shot(0, -1500, "R7", g); chk("R8 low", g, 0);
  endtask

  task automatic t_block();
    int i = 0;
    while (cnt < NB - 1) begin
      drive(i % 8, (i % 32) - 16 + inj());
      i++;
    end
    chk("R6 coef before end", coef_all, 0);
    drive(1, inj());
    for (int j = 0; j < 3; j++) begin
      longint c = coef_at(j);
      longint dv = c - 16 * d[j];
      chk("R5 coef", c, exp_coef[j]);
      chk("R10 converge", (dv <= 16 && dv >= -16), 1);
    end
    gap();
  endtask

  task automatic t_cancel();
    longint g;
    one_shot(3, 250 + inj(), "R7 cancel", g);
    one_shot(6, -900 + inj(), "R7 cancel", g);
    one_shot(1, inj(), "R7 cancel", g);
    one_shot(4, 1203 + inj(), "R7 cancel", g);
  endtask

  task automatic t_sat();
    longint g, cs;
    bit hit = 0;
    for (int k = 0; k < 200 && !hit; k++) begin
      cs = 0;
      for (int i = 0; i < 3; i++) cs += m[i][0] ? coef_at(i) : -coef_at(i);
      if (cs < -16) begin
        one_shot(7, 2047, "R7 sat", g);
        chk("R8 high", g, 16383);
        hit = 1;
      end else begin
        drive(3, inj());
        gap();
      end
    end
    chk("R8 high case found", hit, 1);
    one_shot(0, -2048, "R7 sat", g);
    chk("R8 low", g, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog all-R actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_pn_walk();
    t_transparent();
    t_block();
    t_cancel();
    t_sat();
    for (int i = 0; i < 10; i++) drive(2, inj());
    do_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule